// File: doc/BRIEF.md
# Serial Configuration Write Port

This block receives a write-only three-wire bus made of a data line, a bus clock and an active-low enable, and turns each burst into a write to one of a small set of configuration registers. While the enable line is low, each rising bus-clock edge shifts one data bit into a 19-bit shift register. Bits arrive most significant first. Bits that arrive while the enable line is high are ignored. When the enable line returns high, the word in the shift register is split into a payload and an address, and the payload is copied into the register that the address selects.

The shift register is never cleared and bursts are never counted. A long burst leaves only its final 19 bits. A short burst combines its bits with whatever the previous burst left behind. The three bus lines are asynchronous to the system clock, so they pass through synchronizer stages before use. A bus-active output rises while the enable line is low and stays high for a fixed number of system clocks after the enable line is released. This output is meant for waking up the logic around the interface. The configuration registers keep their values for as long as no new write reaches them.

Top module: `serprog_rx`

## Requirements
- R1: While the enable line is low, each rising bus-clock edge shifts `bus_dat` into the shift register, most significant bit first. The first bit of a 19-bit burst therefore becomes word bit 18.
- R2: Bus-clock edges and data values that occur while the enable line is high leave the shift register unchanged.
- R3: Only the last 19 bits clocked in are kept. In a burst longer than 19 bits, the leading bits have no effect.
- R4: Bursts are not length-checked. A burst of k < 19 bits shifts the previous contents up by k places and fills the low k bits with the new bits.
- R5: Word bits [1:0], the last two bits clocked in, select register 0..3. Word bits [18:2] are written into that register, and all other registers are left unchanged.
- R6: The transfer takes place only when the enable line rises. No register changes while bits are being clocked in.
- R7: `bus_active` goes high within 4 system clocks of the enable line going low.
- R8: `bus_active` stays high for at least 8 system clocks after the enable line returns high, then falls within 12 system clocks and stays low while the bus is idle.
- R9: After reset, all configuration registers are zero and `bus_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_dat | input | 1 | Serial data line |
| bus_clk | input | 1 | Serial bus clock; data is sampled on its rising edge |
| bus_en_n | input | 1 | Active-low burst enable; its rising edge commits the word |
| cfg_q | output | 68 | Four 17-bit configuration registers; register i occupies bits [17*i+16 : 17*i] |
| bus_active | output | 1 | High while the bus is in use and for a hold time after it |

## Verification
The embedded assertions check the following on every cycle:
- the shift register holds its value whenever no enabled bus-clock edge is detected;
- the register bank changes only on a commit;
- at most one register is written at a time;
- `bus_active` follows a low enable;
- the hold counter stays within its bound.

The bench covers what only whole bursts can show:
- the most-significant-first bit order;
- leading bits dropped from long bursts, and short bursts merged with earlier contents;
- clock edges ignored while the enable line is high, shown through an empty burst that re-commits the shift register;
- the timing window of `bus_active` after release.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

   // Default geometry of the configuration port
   localparam int SP_WORD_W      = 19;
   localparam int SP_ADDR_W      = 2;
   localparam int SP_NUM_REGS    = 4;
   localparam int SP_SYNC_STAGES = 2;
   localparam int SP_HOLD_CYCLES = 8;

   // Phase of the bus-active tracker
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_BUSY = 2'd1,
      WK_HOLD = 2'd2
   } wake_state_e;

   // Counter width that can hold the value n
   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      if (WIDTH < 1) $error("serprog_sync: WIDTH must be at least 1");
      if (STAGES < 0) $error("serprog_sync: STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/serprog_shift.sv
module serprog_shift #(
   parameter int WORD_W    = 19,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] word
);

   logic [WORD_W-1:0] sr;

   initial begin
      if (WORD_W < 2) $error("serprog_shift: WORD_W must be at least 2");
   end

   generate
      if (MSB_FIRST) begin : g_msb
         // Newest bit enters at the bottom; oldest falls off the top
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr <= '0;
            else if (shift_en) sr <= {sr[WORD_W-2:0], din};
         end
         assign word = sr;
      end else begin : g_lsb
         // Newest bit enters at the top; word is mirrored so the
         // last bits received still land in the low field
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr <= '0;
            else if (shift_en) sr <= {din, sr[WORD_W-1:1]};
         end
         always_comb begin
            for (int i = 0; i < WORD_W; i++) word[i] = sr[WORD_W-1-i];
         end
      end
   endgenerate

   // R2: without an enabled edge the register keeps its contents
   a_r2_hold_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sr));

   // R1: an enabled edge always moves the register
   a_r1_shift_moves : assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (sr == $past({sr[WORD_W-2:0], din})) || !MSB_FIRST);

endmodule

// File: rtl/serprog_bank.sv
module serprog_bank #(
   parameter int PAY_W    = 17,
   parameter int ADDR_W   = 2,
   parameter int NUM_REGS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      commit,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [PAY_W-1:0]          payload,
   output logic [NUM_REGS*PAY_W-1:0] regs_flat
);

   logic [NUM_REGS-1:0] wr_sel;
   logic [PAY_W-1:0]    regs [NUM_REGS];

   initial begin
      if (NUM_REGS < 1) $error("serprog_bank: NUM_REGS must be at least 1");
      if (NUM_REGS > (1 << ADDR_W)) $error("serprog_bank: NUM_REGS exceeds address space");
   end

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         assign wr_sel[g] = commit && (addr == ADDR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         regs[g] <= '0;
            else if (wr_sel[g]) regs[g] <= payload;
         end

         assign regs_flat[g*PAY_W +: PAY_W] = regs[g];

         // R5: a register changes only when it is the addressed one
         a_r5_only_target : assert property (@(posedge clk) disable iff (!rst_n)
            (!commit || addr != ADDR_W'(g)) |=> $stable(regs[g]));
      end
   endgenerate

   // R5: never more than one destination per commit
   a_r5_single_write : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

   // R6: the whole bank is frozen between commits
   a_r6_frozen_between_commits : assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(regs_flat));

endmodule

// File: rtl/serprog_wake.sv
module serprog_wake
   import serprog_pkg::*;
#(
   parameter int HOLD_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_n_s,
   output logic active
);

   localparam int CNT_W = cnt_width(HOLD_CYCLES);
   localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES);

   wake_state_e      st;
   logic [CNT_W-1:0] cnt;

   initial begin
      if (HOLD_CYCLES < 1) $error("serprog_wake: HOLD_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= WK_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            WK_IDLE: if (!en_n_s) st <= WK_BUSY;
            WK_BUSY: if (en_n_s) begin
               st  <= WK_HOLD;
               cnt <= HOLD_LOAD;
            end
            WK_HOLD: begin
               if (!en_n_s)          st  <= WK_BUSY;
               else if (cnt == '0)   st  <= WK_IDLE;
               else                  cnt <= cnt - 1'b1;
            end
            default: st <= WK_IDLE;
         endcase
      end
   end

   assign active = (st != WK_IDLE);

   // R7: a low enable always leads to an active interface
   a_r7_wake_on_enable : assert property (@(posedge clk) disable iff (!rst_n)
      !en_n_s |=> active);

   // R8: the hold countdown never exceeds its load value
   a_r8_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= HOLD_LOAD);

   // R8: the interface only goes idle from an expired hold
   a_r8_idle_after_hold : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(st) == WK_HOLD && $past(cnt) == '0));

endmodule

// File: rtl/serprog_rx.sv
module serprog_rx
   import serprog_pkg::*;
#(
   parameter int WORD_W      = SP_WORD_W,
   parameter int ADDR_W      = SP_ADDR_W,
   parameter int NUM_REGS    = SP_NUM_REGS,
   parameter int SYNC_STAGES = SP_SYNC_STAGES,
   parameter int HOLD_CYCLES = SP_HOLD_CYCLES,
   parameter bit MSB_FIRST   = 1'b1,
   localparam int PAY_W      = WORD_W - ADDR_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_dat,
   input  logic                      bus_clk,
   input  logic                      bus_en_n,
   output logic [NUM_REGS*PAY_W-1:0] cfg_q,
   output logic                      bus_active
);

   initial begin
      if (ADDR_W < 1)       $error("serprog_rx: ADDR_W must be at least 1");
      if (WORD_W <= ADDR_W) $error("serprog_rx: WORD_W must exceed ADDR_W");
   end

   // Synchronized bus lines: {enable_n, clock, data}
   logic [2:0]        bus_s;
   logic              s_dat, s_clk, s_en_n;
   logic              clk_d, en_d;
   logic              shift_en, commit;
   logic [WORD_W-1:0] word;

   serprog_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_en_n, bus_clk, bus_dat}),
      .q     (bus_s)
   );

   assign {s_en_n, s_clk, s_dat} = bus_s;

   // Edge detection on the synchronized lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d <= 1'b0;
         en_d  <= 1'b1;
      end else begin
         clk_d <= s_clk;
         en_d  <= s_en_n;
      end
   end

   assign shift_en = s_clk & ~clk_d & ~s_en_n;
   assign commit   = s_en_n & ~en_d;

   serprog_shift #(
      .WORD_W    (WORD_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (s_dat),
      .word     (word)
   );

   serprog_bank #(
      .PAY_W    (PAY_W),
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .addr      (word[ADDR_W-1:0]),
      .payload   (word[WORD_W-1:ADDR_W]),
      .regs_flat (cfg_q)
   );

   serprog_wake #(
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_n_s (s_en_n),
      .active (bus_active)
   );

   // R6: a commit only follows a period of low enable
   a_r6_commit_after_burst : assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(!s_en_n));

   // R2: a shift is never seen together with a commit
   a_r2_no_shift_on_commit : assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_en && commit));

endmodule

// File: tb/tb_serprog_rx.sv
module tb_serprog_rx;

   localparam int WORD_W = 19;
   localparam int ADDR_W = 2;
   localparam int NREG   = 4;
   localparam int PAY_W  = WORD_W - ADDR_W;
   localparam int HOLD   = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic bus_dat, bus_clk, bus_en_n;
   logic [NREG*PAY_W-1:0] cfg_q;
   logic bus_active;

   int n_chk  = 0;
   int n_fail = 0;

   // Bench model
   logic [WORD_W-1:0] m_sr;
   logic [PAY_W-1:0]  m_reg [NREG];

   always #2.5 clk = ~clk;

   serprog_rx dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_dat    (bus_dat),
      .bus_clk    (bus_clk),
      .bus_en_n   (bus_en_n),
      .cfg_q      (cfg_q),
      .bus_active (bus_active)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_bank(input string req);
      for (int i = 0; i < NREG; i++)
         chk(req, 32'(cfg_q[i*PAY_W +: PAY_W]), 32'(m_reg[i]));
   endtask

   function automatic logic [WORD_W-1:0] model_shift(input logic [WORD_W-1:0] sr,
                                                     input logic [63:0] bits, input int n);
      logic [WORD_W-1:0] r;
      r = sr;
      for (int i = n - 1; i >= 0; i--) r = {r[WORD_W-2:0], bits[i]};
      return r;
   endfunction

   task automatic send_bit(input logic b);
      bus_dat = b;
      cyc(4);
      bus_clk = 1'b1;
      cyc(4);
      bus_clk = 1'b0;
   endtask

   // Full burst; the first bit sent is bits[n-1]
   task automatic burst(input logic [63:0] bits, input int n, input string req);
      bus_en_n = 1'b0;
      cyc(4);
      chk("R7", 32'(bus_active), 32'd1);
      for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
      cyc(4);
      chk_bank({req, "/R6"});
      bus_en_n = 1'b1;
      m_sr = model_shift(m_sr, bits, n);
      m_reg[m_sr[ADDR_W-1:0]] = m_sr[WORD_W-1:ADDR_W];
      cyc(HOLD - 1);
      chk("R8", 32'(bus_active), 32'd1);
      cyc(6);
      chk_bank(req);
   endtask

   task automatic idle_toggle(input int n);
      for (int i = 0; i < n; i++) send_bit(1'($urandom));
   endtask

   function automatic logic [63:0] mk(input logic [PAY_W-1:0] p, input logic [1:0] a);
      return 64'({p, a});
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; bus_dat = 1'b0; bus_clk = 1'b0; bus_en_n = 1'b1;
      m_sr = '0;
      for (int i = 0; i < NREG; i++) m_reg[i] = '0;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R9 reset state
      chk_bank("R9");
      chk("R9", 32'(bus_active), 32'd0);

      // R5 one write per register, MSB first (R1)
      burst(mk(17'h1_2345, 2'd0), 19, "R1");
      burst(mk(17'h0_ABCD, 2'd1), 19, "R5");
      burst(mk(17'h1_FFFF, 2'd2), 19, "R5");
      burst(mk(17'h0_0001, 2'd3), 19, "R5");
      cyc(10);
      chk("R8", 32'(bus_active), 32'd0);

      // R3 long burst: leading 6 bits are junk
      burst({39'd0, 6'b101101, 17'h0_5A5A, 2'd2}, 25, "R3");

      // R4 short burst merges with previous contents
      burst(64'b10111, 5, "R4");

      // R2 edges with enable high, then an empty burst recommits
      idle_toggle(7);
      burst(64'd0, 0, "R2");

      // Random bursts
      for (int k = 0; k < 60; k++) begin
         logic [63:0] b;
         int          n;
         b = {$urandom, $urandom};
         n = $urandom_range(0, 30);
         if (($urandom % 4) == 0) idle_toggle($urandom_range(1, 6));
         burst(b, n, "R5");
      end

      cyc(HOLD + 8);
      chk("R8", 32'(bus_active), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule